// File: doc/BRIEF.md
# DC Force-and-Measure Controller

This block is the digital sequencer for one parametric channel that forces a voltage or a current into a device pin and measures the response. Software presents a force mode, a force value, clamp values, a settle count and two comparison limits, each limit with its own enable, and then pulses a start input. The controller clips the force value to the full scale of the selected force range and hands it to a DAC over a valid/ready port. It then closes the connect relay, waits the programmed number of settle cycles and takes one sample from an ADC over a ready/valid port. It saturates that sample to the selected measure range and compares it against the enabled limits.

When the result is ready, a one-cycle done pulse is raised and the relay is opened. The pass, fail-high and fail-low flags stay put until the next start. The measured quantity always follows the force mode: forcing voltage measures current, and forcing current measures voltage. The protective clamp sent to the analog side is the one that belongs to the forced quantity. A configuration whose clamp could never let the upper-limit test fail is flagged. The force and measure ranges live in their own registers. A write to them is refused while a measurement is running, which covers the whole time the relay is closed. The analog parts and the converters are outside this block.

Top module: `dmu_ctrl`

## Requirements
- R1: `meas_curr_o` is 1 (measure current) when voltage forcing is selected (`force_cur_i`=0), and 0 (measure voltage) when current forcing is selected. It is taken at start and held through the measurement. After reset it is 1.
- R2: The full scale of range code c (3 bits) is 256·2^c − 1. `dac_data_o` equals the force value clipped to ±full scale of the force range, and it is offered with `dac_valid_o` from the cycle after start until `dac_ready_i` is seen.
- R3: `meas_o` equals the accepted ADC sample saturated to ±full scale of the measure range.
- R4: `fail_hi_o` is set when the upper limit is enabled and the measurement is strictly greater than it. Equality does not fail.
- R5: `fail_lo_o` is set when the lower limit is enabled and the measurement is strictly less than it. Equality does not fail.
- R6: `pass_o` is set exactly when neither fail flag is set. With both limits disabled, every measurement passes.
- R7: A range write (`rng_we_i`) made while a measurement is running is ignored and sets `rng_err_o`. A write made while idle is accepted and clears `rng_err_o`. Both ranges reset to code 7.
- R8: `clamp_o` carries the current clamp in voltage-force mode and the voltage clamp in current-force mode.
- R9: `cfg_bad_o` is set for a measurement whose upper limit is enabled and whose active clamp is less than or equal to the upper limit.
- R10: The relay closes on the DAC handshake. `adc_ready_o` rises exactly settle+1 cycles after `relay_o` rises. The cycle after the sample is accepted, `done_o` pulses for one cycle while the relay opens. The flags hold until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a measurement (taken when idle) |
| force_cur_i | input | 1 | 0 = force voltage, 1 = force current |
| force_val_i | input | 16 | Requested force value, signed |
| vclamp_i | input | 16 | Voltage clamp, signed |
| iclamp_i | input | 16 | Current clamp, signed |
| hi_lim_i | input | 16 | Upper limit, signed |
| lo_lim_i | input | 16 | Lower limit, signed |
| hi_en_i | input | 1 | Upper limit enable |
| lo_en_i | input | 1 | Lower limit enable |
| settle_i | input | 8 | Settle cycles after relay close |
| rng_we_i | input | 1 | Range write strobe |
| frange_i | input | 3 | Force range code to write |
| mrange_i | input | 3 | Measure range code to write |
| dac_ready_i | input | 1 | DAC accepts setpoint |
| adc_valid_i | input | 1 | ADC sample valid |
| adc_data_i | input | 16 | ADC sample, signed |
| dac_valid_o | output | 1 | Setpoint offered |
| dac_data_o | output | 16 | Clipped setpoint |
| adc_ready_o | output | 1 | Controller takes a sample |
| relay_o | output | 1 | Connect relay closed |
| meas_curr_o | output | 1 | 1 = measuring current |
| clamp_o | output | 16 | Active clamp value |
| meas_o | output | 16 | Saturated measurement |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Measurement passed |
| fail_hi_o | output | 1 | Above enabled upper limit |
| fail_lo_o | output | 1 | Below enabled lower limit |
| cfg_bad_o | output | 1 | Clamp not outside upper limit |
| rng_err_o | output | 1 | A range write was refused |

## Verification
The hardest case to reach is a refused range write. The write has to land in the narrow window while the relay is closed, and its effect only shows indirectly. The stimulus issues a write with different codes on the first cycle of the settle wait. It then checks that the refusal flag rises and that the measurement is still saturated, and the next setpoint still clipped, with the old codes. Limit boundaries are reached by placing each limit at the expected saturated value plus a small random offset, so equality and off-by-one cases occur often.

// File: rtl/dmu_pkg.sv
package dmu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_CMP
  } dmu_state_e;

  // full scale of a range code: base * 2^code - 1
  function automatic int unsigned dmu_full_scale(input int unsigned base, input logic [2:0] code);
    return (base << code) - 1;
  endfunction

endpackage

// File: rtl/dmu_sat.sv
module dmu_sat #(
  parameter int DW   = 16,
  parameter int RW   = 3,
  parameter int BASE = 256
) (
  input  logic signed [DW-1:0] val_i,
  input  logic        [RW-1:0] code_i,
  output logic signed [DW-1:0] val_o
);
  import dmu_pkg::*;

  logic signed [DW:0] fs, ext;

  assign fs  = $signed((DW+1)'(dmu_full_scale(BASE, code_i)));
  assign ext = {val_i[DW-1], val_i};

  always_comb begin
    if (ext > fs)       val_o = fs[DW-1:0];
    else if (ext < -fs) val_o = DW'(-fs);
    else                val_o = val_i;
  end

endmodule

// File: rtl/dmu_range_regs.sv
module dmu_range_regs #(
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] frange_i,
  input  logic [RW-1:0] mrange_i,
  input  logic          lock_i,
  output logic [RW-1:0] frange_o,
  output logic [RW-1:0] mrange_o,
  output logic          err_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frange_o <= '1;
      mrange_o <= '1;
      err_o    <= 1'b0;
    end else if (we_i) begin
      if (lock_i) begin
        err_o <= 1'b1;
      end else begin
        frange_o <= frange_i;
        mrange_o <= mrange_i;
        err_o    <= 1'b0;
      end
    end
  end

  assert_rng_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_i) |=> ($stable(frange_o) && $stable(mrange_o) && err_o));

endmodule

// File: rtl/dmu_limit_chk.sv
module dmu_limit_chk #(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 cmp_i,
  input  logic signed [DW-1:0] meas_i,
  input  logic signed [DW-1:0] hi_i,
  input  logic signed [DW-1:0] lo_i,
  input  logic                 hi_en_i,
  input  logic                 lo_en_i,
  output logic                 pass_o,
  output logic                 fhi_o,
  output logic                 flo_o
);

  logic above, below;
  assign above = hi_en_i && (meas_i > hi_i);
  assign below = lo_en_i && (meas_i < lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o <= 1'b0;
      fhi_o  <= 1'b0;
      flo_o  <= 1'b0;
    end else if (clr_i) begin
      pass_o <= 1'b0;
      fhi_o  <= 1'b0;
      flo_o  <= 1'b0;
    end else if (cmp_i) begin
      fhi_o  <= above;
      flo_o  <= below;
      pass_o <= !(above || below);
    end
  end

  assert_pass_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (!fhi_o && !flo_o));

  assert_disabled_lims_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && !hi_en_i && !lo_en_i) |=> pass_o);

endmodule

// File: rtl/dmu_ctrl.sv
module dmu_ctrl #(
  parameter int DW   = 16,
  parameter int RW   = 3,
  parameter int SW   = 8,
  parameter int BASE = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          force_cur_i,
  input  logic [DW-1:0] force_val_i,
  input  logic [DW-1:0] vclamp_i,
  input  logic [DW-1:0] iclamp_i,
  input  logic [DW-1:0] hi_lim_i,
  input  logic [DW-1:0] lo_lim_i,
  input  logic          hi_en_i,
  input  logic          lo_en_i,
  input  logic [SW-1:0] settle_i,
  input  logic          rng_we_i,
  input  logic [RW-1:0] frange_i,
  input  logic [RW-1:0] mrange_i,
  input  logic          dac_ready_i,
  input  logic          adc_valid_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          dac_valid_o,
  output logic [DW-1:0] dac_data_o,
  output logic          adc_ready_o,
  output logic          relay_o,
  output logic          meas_curr_o,
  output logic [DW-1:0] clamp_o,
  output logic [DW-1:0] meas_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_hi_o,
  output logic          fail_lo_o,
  output logic          cfg_bad_o,
  output logic          rng_err_o
);
  import dmu_pkg::*;

  dmu_state_e state_q;
  logic [SW-1:0] cnt_q;
  logic force_cur_q, hi_en_q, lo_en_q, cfg_bad_q, done_q, relay_q;
  logic signed [DW-1:0] dac_q, clamp_q, hi_q, lo_q, meas_q;
  logic signed [DW-1:0] force_clip, meas_sat, act_clamp;
  logic [RW-1:0] frange_q, mrange_q;
  logic busy, accept_start;

  assign busy         = (state_q != ST_IDLE);
  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign act_clamp    = force_cur_i ? $signed(vclamp_i) : $signed(iclamp_i);

  dmu_range_regs #(.RW(RW)) u_ranges (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rng_we_i),
    .frange_i (frange_i),
    .mrange_i (mrange_i),
    .lock_i   (busy),
    .frange_o (frange_q),
    .mrange_o (mrange_q),
    .err_o    (rng_err_o)
  );

  dmu_sat #(.DW(DW), .RW(RW), .BASE(BASE)) u_force_sat (
    .val_i  ($signed(force_val_i)),
    .code_i (frange_q),
    .val_o  (force_clip)
  );

  dmu_sat #(.DW(DW), .RW(RW), .BASE(BASE)) u_meas_sat (
    .val_i  ($signed(adc_data_i)),
    .code_i (mrange_q),
    .val_o  (meas_sat)
  );

  dmu_limit_chk #(.DW(DW)) u_limits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept_start),
    .cmp_i   (state_q == ST_CMP),
    .meas_i  (meas_q),
    .hi_i    (hi_q),
    .lo_i    (lo_q),
    .hi_en_i (hi_en_q),
    .lo_en_i (lo_en_q),
    .pass_o  (pass_o),
    .fhi_o   (fail_hi_o),
    .flo_o   (fail_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      force_cur_q <= 1'b0;
      hi_en_q     <= 1'b0;
      lo_en_q     <= 1'b0;
      cfg_bad_q   <= 1'b0;
      done_q      <= 1'b0;
      relay_q     <= 1'b0;
      dac_q       <= '0;
      clamp_q     <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      meas_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          force_cur_q <= force_cur_i;
          dac_q       <= force_clip;
          clamp_q     <= act_clamp;
          hi_q        <= $signed(hi_lim_i);
          lo_q        <= $signed(lo_lim_i);
          hi_en_q     <= hi_en_i;
          lo_en_q     <= lo_en_i;
          // a clamp at or inside the upper limit masks the failure it guards
          cfg_bad_q   <= hi_en_i && (act_clamp <= $signed(hi_lim_i));
          cnt_q       <= settle_i;
          state_q     <= ST_DRIVE;
        end
        ST_DRIVE: if (dac_ready_i) begin
          relay_q <= 1'b1;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt_q == '0) state_q <= ST_SAMPLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_SAMPLE: if (adc_valid_i) begin
          meas_q  <= meas_sat;
          state_q <= ST_CMP;
        end
        ST_CMP: begin
          done_q  <= 1'b1;
          relay_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_valid_o = (state_q == ST_DRIVE);
  assign dac_data_o  = dac_q;
  assign adc_ready_o = (state_q == ST_SAMPLE);
  assign relay_o     = relay_q;
  assign meas_curr_o = !force_cur_q;
  assign clamp_o     = clamp_q;
  assign meas_o      = meas_q;
  assign done_o      = done_q;
  assign cfg_bad_o   = cfg_bad_q;

  // ranges are frozen while busy, so bounds below are stable references
  logic signed [DW:0] fs_f, fs_m, dac_x, meas_x;
  assign fs_f   = $signed((DW+1)'(dmu_full_scale(BASE, frange_q)));
  assign fs_m   = $signed((DW+1)'(dmu_full_scale(BASE, mrange_q)));
  assign dac_x  = {dac_q[DW-1], dac_q};
  assign meas_x = {meas_q[DW-1], meas_q};

  assert_dac_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |-> ((dac_x <= fs_f) && (dac_x >= -fs_f)));

  assert_meas_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((meas_x <= fs_m) && (meas_x >= -fs_m)));

  assert_sample_conn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_ready_o |-> relay_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_mode_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relay_o && $past(relay_o)) |-> $stable(meas_curr_o));

  assert_clamp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relay_o && $past(relay_o)) |-> $stable(clamp_o));

endmodule

// File: tb/tb_dmu_ctrl.sv
module tb_dmu_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start, force_cur, hi_en, lo_en, rng_we, dac_ready, adc_valid;
  logic signed [15:0] force_val, vclamp, iclamp, hi_lim, lo_lim, adc_data;
  logic [7:0] settle;
  logic [2:0] frange, mrange;
  logic dac_valid, adc_ready, relay, meas_curr, done, pass, fail_hi, fail_lo, cfg_bad, rng_err;
  logic [15:0] dac_data, clamp, meas;

  dmu_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .force_cur_i(force_cur),
    .force_val_i(force_val), .vclamp_i(vclamp), .iclamp_i(iclamp),
    .hi_lim_i(hi_lim), .lo_lim_i(lo_lim), .hi_en_i(hi_en), .lo_en_i(lo_en),
    .settle_i(settle), .rng_we_i(rng_we), .frange_i(frange), .mrange_i(mrange),
    .dac_ready_i(dac_ready), .adc_valid_i(adc_valid), .adc_data_i(adc_data),
    .dac_valid_o(dac_valid), .dac_data_o(dac_data), .adc_ready_o(adc_ready),
    .relay_o(relay), .meas_curr_o(meas_curr), .clamp_o(clamp), .meas_o(meas),
    .done_o(done), .pass_o(pass), .fail_hi_o(fail_hi), .fail_lo_o(fail_lo),
    .cfg_bad_o(cfg_bad), .rng_err_o(rng_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int fr_m = 7;
  int mr_m = 7;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fsv(input int code);
    return (256 << code) - 1;
  endfunction

  function automatic int clipv(input int v, input int code);
    int f = fsv(code);
    if (v > f) return f;
    if (v < -f) return -f;
    return v;
  endfunction

  task automatic set_ranges(input int fr, input int mr);
    @(negedge clk);
    rng_we = 1'b1; frange = 3'(fr); mrange = 3'(mr);
    @(negedge clk);
    rng_we = 1'b0;
    fr_m = fr; mr_m = mr;
    chk("R7 idle write clears error", int'(rng_err), 0);
  endtask

  task automatic run_meas(input bit cur, input int fv, input int vc, input int ic,
                          input int hi, input int lo, input bit he, input bit le,
                          input int st, input int adc, input int dwait, input bit try_rng);
    int cnt, mexp, act_cl;
    bit fh, fl;
    @(negedge clk);
    force_cur = cur; force_val = 16'(fv); vclamp = 16'(vc); iclamp = 16'(ic);
    hi_lim = 16'(hi); lo_lim = 16'(lo); hi_en = he; lo_en = le; settle = 8'(st);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 dac valid after start", int'(dac_valid), 1);
    chk("R2 dac clipped", int'($signed(dac_data)), clipv(fv, fr_m));
    chk("R6 flags cleared on start", int'({pass, fail_hi, fail_lo}), 0);
    repeat (dwait) @(negedge clk);
    chk("R10 relay open before dac accept", int'(relay), 0);
    dac_ready = 1'b1;
    @(negedge clk);
    dac_ready = 1'b0;
    chk("R10 relay closed on dac accept", int'(relay), 1);
    cnt = 0;
    while (!adc_ready && cnt < 400) begin
      cnt++;
      if (try_rng && cnt == 1) begin
        rng_we = 1'b1; frange = 3'(7 - fr_m); mrange = 3'(7 - mr_m);
      end else if (try_rng && cnt == 2) begin
        rng_we = 1'b0;
        chk("R7 write refused while busy", int'(rng_err), 1);
      end
      @(negedge clk);
    end
    chk("R10 settle cycles", cnt, st + 1);
    adc_valid = 1'b1; adc_data = 16'(adc);
    @(negedge clk);
    adc_valid = 1'b0;
    @(negedge clk);
    mexp = clipv(adc, mr_m);
    fh = he && (mexp > hi);
    fl = le && (mexp < lo);
    act_cl = cur ? vc : ic;
    chk("R10 done pulse", int'(done), 1);
    chk("R10 relay opens", int'(relay), 0);
    chk("R3 meas saturated", int'($signed(meas)), mexp);
    chk("R4 fail high", int'(fail_hi), int'(fh));
    chk("R5 fail low", int'(fail_lo), int'(fl));
    chk("R6 pass", int'(pass), int'(!(fh || fl)));
    chk("R1 measure mode", int'(meas_curr), int'(!cur));
    chk("R8 active clamp", int'($signed(clamp)), act_cl);
    chk("R9 config check", int'(cfg_bad), int'(he && (act_cl <= hi)));
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
    chk("R10 flags held", int'({pass, fail_hi, fail_lo}), int'({!(fh || fl), fh, fl}));
  endtask

  initial begin
    int unsigned seed_dummy;
    start = 0; force_cur = 0; force_val = 0; vclamp = 0; iclamp = 0; hi_lim = 0;
    lo_lim = 0; hi_en = 0; lo_en = 0; settle = 0; rng_we = 0; frange = 0; mrange = 0;
    dac_ready = 0; adc_valid = 0; adc_data = 0;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset relay", int'(relay), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R2 reset dac valid", int'(dac_valid), 0);
    chk("R7 reset error", int'(rng_err), 0);
    chk("R1 reset measure mode", int'(meas_curr), 1);

    // directed: oversize request clipped to range 0 (fs 255)
    set_ranges(0, 0);
    run_meas(0, 1000, 100, 500, 200, -200, 1, 1, 2, 100, 0, 0);
    run_meas(1, -30000, 400, 0, 0, 0, 0, 0, 0, -5000, 1, 0);
    // limit equality boundaries, range 7
    set_ranges(7, 7);
    run_meas(0, 1234, 0, 3000, 1000, -1000, 1, 1, 3, 1000, 0, 0);
    run_meas(0, 1234, 0, 3000, 1000, -1000, 1, 1, 3, 1001, 0, 0);
    run_meas(1, 50, 3000, 0, 1000, -1000, 1, 1, 1, -1000, 2, 0);
    run_meas(1, 50, 3000, 0, 1000, -1000, 1, 1, 1, -1001, 2, 0);
    // only one limit at a time, and neither
    run_meas(0, 9, 0, 9000, 100, 0, 1, 0, 0, -32000, 0, 0);
    run_meas(0, 9, 0, 9000, 100, 0, 0, 1, 0, 32000, 0, 0);
    run_meas(1, 9, 0, 0, 0, 0, 0, 0, 4, 32767, 0, 0);
    // clamp equal to and just above upper limit
    run_meas(0, 0, 0, 700, 700, 0, 1, 0, 1, 0, 0, 0);
    run_meas(0, 0, 0, 701, 700, 0, 1, 0, 1, 0, 0, 0);
    run_meas(1, 0, 700, 9999, 700, 0, 1, 0, 1, 0, 0, 0);
    // refused range write while connected
    set_ranges(1, 2);
    run_meas(0, 20000, 0, 0, 0, 0, 0, 0, 3, -20000, 0, 1);
    run_meas(1, -20000, 0, 0, 0, 0, 0, 0, 0, 20000, 0, 0);

    for (int i = 0; i < 300; i++) begin
      int fv, adc, mexp, hi, lo, st;
      bit tr;
      if ($urandom_range(0, 3) == 0) set_ranges($urandom_range(0, 7), $urandom_range(0, 7));
      fv  = int'($signed(16'($urandom())));
      adc = int'($signed(16'($urandom())));
      mexp = clipv(adc, mr_m);
      hi = mexp + $urandom_range(0, 4) - 2;
      lo = mexp + $urandom_range(0, 4) - 2;
      if (hi > 32767) hi = 32767;
      if (lo < -32768) lo = -32768;
      tr = ($urandom_range(0, 4) == 0);
      st = tr ? $urandom_range(1, 12) : $urandom_range(0, 12);
      run_meas($urandom_range(0, 1), fv,
               int'($signed(16'($urandom()))),
               ($urandom_range(0, 3) == 0) ? hi : int'($signed(16'($urandom()))),
               hi, lo, $urandom_range(0, 1), $urandom_range(0, 1),
               st, adc, $urandom_range(0, 3), tr);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule